// File: doc/BRIEF.md
# Transmit Descriptor Poll Engine

This block is the transmit side of a descriptor-driven DMA engine. Software builds a ring of four-word descriptors in a word-addressed memory, points the engine at the ring through a small register port, enables transmit and then writes a poll demand. The engine walks the ring from its current position. For each descriptor it owns, it reads the buffer, sends it as a little-endian byte stream and writes a completion status back. It stops at the first descriptor it does not own.

A descriptor flagged as a setup packet sends its bytes to a separate setup sink instead of the transmit stream, and it completes with the all-ones-but-ownership status. A non-setup descriptor with a zero length is returned with the error-summary bit set. A software reset through the bus-mode register stops the engine at once.

Top module: `txd_poll_engine`

## Requirements
- R1: Writing a word with bit 0 set to the poll register (address 1) starts processing at the current descriptor only when transmit is enabled by bit 13 of the operation-mode register (address 3). While transmit is disabled, a poll demand changes no state, starts no memory access and produces no bytes.
- R2: Word 0 of a descriptor is its status, and bit 31 is the ownership flag. Only descriptors with that flag set are processed. On completion the status word is rewritten with bit 31 clear, and a normal completion writes 0x00000000.
- R3: On reaching a descriptor it does not own, the engine suspends with process state 6 and writes nothing back. The next poll demand re-examines that same descriptor.
- R4: Word 1 of a descriptor holds the control bits and, in bits 10:0, the buffer length in bytes. Word 2 holds the buffer word address. The buffer is emitted byte 0 first, each word little-endian (bits 7:0 first), and exactly the length in bytes is emitted.
- R5: `tx_first` is high on the first byte of a descriptor whose control bit 29 is set. `tx_last` is high on the final byte of a descriptor whose control bit 30 is set. Neither flag is high on any other byte.
- R6: A descriptor with control bit 27 set sends its bytes on `setup_valid`/`setup_data` and none on `tx_valid`. It completes with status 0x7FFFFFFF.
- R7: A non-setup descriptor with length 0 emits no bytes and completes with status 0x00008000 (bit 15, error summary).
- R8: Descriptor k sits at ring base + 4k, where the ring base is register address 2 and reads back as written. After a descriptor whose control bit 25 is set, the engine continues at the ring base. Writing the ring base also moves the current position there.
- R9: The status register (address 4) returns the process state in bits 22:20 and zero elsewhere. The codes are 0 idle or reset, 1 fetching a descriptor, 2 reading the buffer, 3 writing status and 6 suspended.
- R10: Writing bit 0 of the bus-mode register (address 0) returns the process state to 0 at once, moves the current position to the ring base and stops all further byte output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read request |
| tx_valid | output | 1 | Transmit byte valid |
| tx_data | output | 8 | Transmit byte |
| tx_first | output | 1 | First byte of a first-segment descriptor |
| tx_last | output | 1 | Final byte of a last-segment descriptor |
| setup_valid | output | 1 | Setup-frame byte valid |
| setup_data | output | 8 | Setup-frame byte |

## Verification
Single-descriptor frames are swept over every length from 1 to 9 bytes. These lengths cover whole words, every partial last word and the step onto a second and third word, so a byte-order or trimming fault shows at a specific length. A three-descriptor ring with mixed segment flags shows that the first and last markers belong to the frame and not to each descriptor, and that the ring wraps at the end-of-ring bit. Separate cases cover the setup, zero-length, unowned and transmit-disabled descriptors, each identified by its written-back status and by which sink received bytes. A software reset issued mid-buffer, followed by a new poll, shows that output stops and that the position returns to the ring base.

// File: rtl/txd_pkg.sv
package txd_pkg;

    localparam int OWN_BIT   = 31;
    localparam int LS_BIT    = 30;
    localparam int FS_BIT    = 29;
    localparam int SETUP_BIT = 27;
    localparam int EOR_BIT   = 25;
    localparam int TXEN_BIT  = 13;
    localparam int SWR_BIT   = 0;

    localparam logic [31:0] STS_SETUP_DONE = 32'h7FFF_FFFF;
    localparam logic [31:0] STS_ERR_DONE   = 32'h0000_8000;
    localparam logic [31:0] STS_OK_DONE    = 32'h0000_0000;

    typedef enum logic [2:0] {
        RA_BUSMODE = 3'd0,
        RA_POLL    = 3'd1,
        RA_RING    = 3'd2,
        RA_OPMODE  = 3'd3,
        RA_STATUS  = 3'd4
    } reg_addr_e;

    typedef enum logic [3:0] {
        ST_IDLE, ST_F_STS, ST_F_CTL, ST_F_BUF, ST_F_ADR,
        ST_B_RD, ST_B_CAP, ST_EMIT, ST_CLOSE, ST_SUSP
    } eng_st_e;

    typedef struct packed {
        logic last;
        logic first;
        logic setup;
        logic eor;
    } desc_flags_t;

    function automatic logic [2:0] proc_code(eng_st_e s);
        case (s)
            ST_F_STS, ST_F_CTL, ST_F_BUF, ST_F_ADR: return 3'd1;
            ST_B_RD, ST_B_CAP, ST_EMIT:             return 3'd2;
            ST_CLOSE:                               return 3'd3;
            ST_SUSP:                                return 3'd6;
            default:                                return 3'd0;
        endcase
    endfunction

endpackage

// File: rtl/txd_regs.sv
module txd_regs
    import txd_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [2:0]        addr,
    input  logic [31:0]       wdata,
    input  logic [2:0]        proc_state,
    output logic [31:0]       rdata,
    output logic              tx_en,
    output logic              poll_go,
    output logic              swr_go,
    output logic              base_load,
    output logic [ADDR_W-1:0] base_next,
    output logic [ADDR_W-1:0] base_q
);

    logic [31:0] opmode_q;

    assign poll_go   = wr && (addr == RA_POLL)    && wdata[0];
    assign swr_go    = wr && (addr == RA_BUSMODE) && wdata[SWR_BIT];
    assign base_load = wr && (addr == RA_RING);
    assign base_next = wdata[ADDR_W-1:0];
    assign tx_en     = opmode_q[TXEN_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            opmode_q <= '0;
            base_q   <= '0;
        end else begin
            if (wr && addr == RA_OPMODE) opmode_q <= wdata;
            if (base_load)               base_q   <= base_next;
        end
    end

    always_comb begin
        case (addr)
            RA_RING:   rdata = 32'(base_q);
            RA_OPMODE: rdata = opmode_q;
            RA_STATUS: rdata = {9'd0, proc_state, 20'd0};
            default:   rdata = '0;
        endcase
    end

endmodule

// File: rtl/txd_lane.sv
module txd_lane #(
    parameter int LANES = 4
) (
    input  logic [8*LANES-1:0]         word,
    input  logic [$clog2(LANES)-1:0]   sel,
    output logic [7:0]                 byte_o
);

    logic [7:0] lanes [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lanes[g] = word[8*g +: 8];
    end

    assign byte_o = lanes[sel];

endmodule

// File: rtl/txd_fsm.sv
module txd_fsm
    import txd_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int LEN_W  = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tx_en,
    input  logic              poll_go,
    input  logic              swr_go,
    input  logic              base_load,
    input  logic [ADDR_W-1:0] base_next,
    input  logic [ADDR_W-1:0] base_q,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    output logic [31:0]       word_q,
    output logic [1:0]        lane,
    output logic              emit_tx,
    output logic              emit_setup,
    output logic              mark_first,
    output logic              mark_last,
    output logic [2:0]        proc_state
);

    localparam logic [ADDR_W-1:0] DESC_STRIDE = ADDR_W'(4);
    localparam logic [LEN_W-1:0]  ONE_LEFT    = LEN_W'(1);

    eng_st_e          st;
    desc_flags_t      flags;
    logic [ADDR_W-1:0] desc_ptr, buf_ptr;
    logic [LEN_W-1:0]  len_q, left;
    logic              first_pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_IDLE;
            flags      <= '0;
            desc_ptr   <= '0;
            buf_ptr    <= '0;
            len_q      <= '0;
            left       <= '0;
            word_q     <= '0;
            lane       <= '0;
            first_pend <= 1'b0;
        end else if (swr_go) begin
            st       <= ST_IDLE;
            desc_ptr <= base_q;
        end else begin
            if (base_load) desc_ptr <= base_next;
            case (st)
                ST_IDLE, ST_SUSP: if (poll_go && tx_en) st <= ST_F_STS;
                ST_F_STS: st <= ST_F_CTL;
                ST_F_CTL: st <= mem_rdata[OWN_BIT] ? ST_F_BUF : ST_SUSP;
                ST_F_BUF: begin
                    flags <= '{last:  mem_rdata[LS_BIT],
                               first: mem_rdata[FS_BIT],
                               setup: mem_rdata[SETUP_BIT],
                               eor:   mem_rdata[EOR_BIT]};
                    len_q <= mem_rdata[LEN_W-1:0];
                    st    <= ST_F_ADR;
                end
                ST_F_ADR: begin
                    buf_ptr    <= mem_rdata[ADDR_W-1:0];
                    left       <= len_q;
                    first_pend <= 1'b1;
                    st         <= (len_q == '0) ? ST_CLOSE : ST_B_RD;
                end
                ST_B_RD: begin
                    buf_ptr <= buf_ptr + ADDR_W'(1);
                    st      <= ST_B_CAP;
                end
                ST_B_CAP: begin
                    word_q <= mem_rdata;
                    lane   <= '0;
                    st     <= ST_EMIT;
                end
                ST_EMIT: begin
                    first_pend <= 1'b0;
                    left       <= left - ONE_LEFT;
                    lane       <= lane + 2'd1;
                    if (left == ONE_LEFT)  st <= ST_CLOSE;
                    else if (lane == 2'd3) st <= ST_B_RD;
                end
                ST_CLOSE: begin
                    if (!base_load)
                        desc_ptr <= flags.eor ? base_q : desc_ptr + DESC_STRIDE;
                    st <= ST_F_STS;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        mem_req  = 1'b0;
        mem_we   = 1'b0;
        mem_addr = desc_ptr;
        case (st)
            ST_F_STS: mem_req = 1'b1;
            ST_F_CTL: begin mem_req = 1'b1; mem_addr = desc_ptr + ADDR_W'(1); end
            ST_F_BUF: begin mem_req = 1'b1; mem_addr = desc_ptr + ADDR_W'(2); end
            ST_B_RD:  begin mem_req = 1'b1; mem_addr = buf_ptr; end
            ST_CLOSE: begin mem_req = 1'b1; mem_we = 1'b1; end
            default: ;
        endcase
    end

    assign mem_wdata  = flags.setup      ? STS_SETUP_DONE :
                        (len_q == '0)    ? STS_ERR_DONE   : STS_OK_DONE;
    assign emit_tx    = (st == ST_EMIT) && !flags.setup;
    assign emit_setup = (st == ST_EMIT) &&  flags.setup;
    assign mark_first = emit_tx && first_pend && flags.first;
    assign mark_last  = emit_tx && (left == ONE_LEFT) && flags.last;
    assign proc_state = proc_code(st);

endmodule

// File: rtl/txd_poll_engine.sv
module txd_poll_engine
    import txd_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int LEN_W  = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    output logic              tx_first,
    output logic              tx_last,
    output logic              setup_valid,
    output logic [7:0]        setup_data
);

    logic              tx_en, poll_go, swr_go, base_load;
    logic [ADDR_W-1:0] base_next, base_q;
    logic [2:0]        proc_state;
    logic [31:0]       word_q;
    logic [1:0]        lane;
    logic [7:0]        cur_byte;

    txd_regs #(.ADDR_W(ADDR_W)) regs_i (
        .clk(clk), .rst(rst), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
        .proc_state(proc_state), .rdata(reg_rdata), .tx_en(tx_en),
        .poll_go(poll_go), .swr_go(swr_go), .base_load(base_load),
        .base_next(base_next), .base_q(base_q)
    );

    txd_fsm #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) fsm_i (
        .clk(clk), .rst(rst), .tx_en(tx_en), .poll_go(poll_go), .swr_go(swr_go),
        .base_load(base_load), .base_next(base_next), .base_q(base_q),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .word_q(word_q),
        .lane(lane), .emit_tx(tx_valid), .emit_setup(setup_valid),
        .mark_first(tx_first), .mark_last(tx_last), .proc_state(proc_state)
    );

    txd_lane #(.LANES(4)) lane_i (
        .word(word_q), .sel(lane), .byte_o(cur_byte)
    );

    assign tx_data    = cur_byte;
    assign setup_data = cur_byte;

endmodule

// File: rtl/txd_poll_chk.sv
module txd_poll_chk (
    input logic        clk,
    input logic        rst,
    input logic        reg_wr,
    input logic [2:0]  reg_addr,
    input logic [31:0] reg_wdata,
    input logic        mem_req,
    input logic        mem_we,
    input logic [31:0] mem_wdata,
    input logic        tx_valid,
    input logic        tx_last,
    input logic        setup_valid,
    input logic        tx_en,
    input logic [2:0]  proc_state
);

    // R2: every status written back has the ownership flag clear
    p_wb_own_clear_r2: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> !mem_wdata[31]);

    // R6: a byte never goes to both sinks
    p_sink_excl_r6: assert property (@(posedge clk) disable iff (rst)
        !(tx_valid && setup_valid));

    // R5: the last marker only accompanies a transmit byte
    p_last_marker_r5: assert property (@(posedge clk) disable iff (rst)
        tx_last |-> tx_valid);

    // R10: software reset lands in the idle state
    p_swr_idle_r10: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == 3'd0 && reg_wdata[0]) |=> (proc_state == 3'd0));

    // R1: a poll demand while disabled leaves an idle engine idle
    p_poll_disabled_r1: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == 3'd1 && !tx_en && proc_state == 3'd0)
        |=> (proc_state == 3'd0 && !mem_req));

endmodule

bind txd_poll_engine txd_poll_chk chk_i (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .mem_req(mem_req), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .tx_valid(tx_valid), .tx_last(tx_last),
    .setup_valid(setup_valid), .tx_en(tx_en), .proc_state(proc_state)
);

// File: tb/txd_poll_engine_tb.sv
`timescale 1ns/1ps
module txd_poll_engine_tb_top;

    localparam int ADDR_W = 16;
    localparam int BASE   = 16;
    localparam int BUF0   = 128;
    localparam int BUF1   = 176;
    localparam logic [31:0] OWN = 32'h8000_0000;
    localparam logic [31:0] LS  = 32'h4000_0000;
    localparam logic [31:0] FS  = 32'h2000_0000;
    localparam logic [31:0] SET = 32'h0800_0000;
    localparam logic [31:0] EOR = 32'h0200_0000;
    localparam logic [31:0] TXEN = 32'h0000_2000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic reg_wr = 1'b0;
    logic [2:0] reg_addr = 3'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic mem_req, mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic tx_valid, tx_first, tx_last, setup_valid;
    logic [7:0] tx_data, setup_data;

    logic [31:0] mem [0:255];
    logic [7:0]  cap_d [0:511];
    logic        cap_f [0:511];
    logic        cap_l [0:511];
    int cap_n = 0;
    int set_n = 0;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    txd_poll_engine dut_i (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_first(tx_first), .tx_last(tx_last), .setup_valid(setup_valid),
        .setup_data(setup_data)
    );

    always @(posedge clk) begin
        if (mem_req && !mem_we) mem_rdata <= mem[mem_addr[7:0]];
        if (mem_req && mem_we)  mem[mem_addr[7:0]] <= mem_wdata;
    end

    always @(negedge clk) begin
        if (tx_valid && cap_n < 512) begin
            cap_d[cap_n] = tx_data;
            cap_f[cap_n] = tx_first;
            cap_l[cap_n] = tx_last;
            cap_n = cap_n + 1;
        end
        if (setup_valid && set_n < 512) begin
            if (setup_data !== pat(7, set_n)) begin
                errors = errors + 1;
                $display("FAIL R6 setup byte %0d act %h exp %h", set_n, setup_data, pat(7, set_n));
            end
            set_n = set_n + 1;
        end
    end

    function automatic logic [7:0] pat(int seed, int i);
        return 8'((seed * 31 + i * 7 + 3) & 255);
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s act %h exp %h", tag, act, exp);
        end
    endtask

    task automatic wreg(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rreg(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic fill_buf(input int addr, input int seed, input int nbytes);
        for (int w = 0; w < (nbytes + 3) / 4; w++)
            mem[addr + w] = {pat(seed, 4*w+3), pat(seed, 4*w+2), pat(seed, 4*w+1), pat(seed, 4*w)};
    endtask

    task automatic set_desc(input int k, input logic [31:0] sts, input logic [31:0] ctl, input int bufa);
        mem[BASE + 4*k]     = sts;
        mem[BASE + 4*k + 1] = ctl;
        mem[BASE + 4*k + 2] = 32'(bufa);
        mem[BASE + 4*k + 3] = '0;
    endtask

    task automatic clear_ring();
        for (int i = BASE; i < BASE + 32; i++) mem[i] = '0;
        cap_n = 0;
        set_n = 0;
    endtask

    task automatic poll_wait();
        logic [31:0] v;
        wreg(3'd1, 32'd1);
        for (int i = 0; i < 5000; i++) begin
            rreg(3'd4, v);
            if (v[22:20] == 3'd6) break;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors = errors + 1;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int nf, nl, c0;
        bit ok;
        for (int i = 0; i < 256; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R9: reset state
        rreg(3'd4, v);
        chk(v == 32'd0 && !tx_valid && !mem_req, "R9 reset state", v, 32'd0);

        wreg(3'd2, 32'(BASE));
        rreg(3'd2, v);
        chk(v == 32'(BASE), "R8 ring base readback", v, 32'(BASE));

        // R1: poll while disabled is ignored
        clear_ring();
        set_desc(0, OWN, FS | LS | EOR | 32'd4, BUF0);
        fill_buf(BUF0, 1, 4);
        wreg(3'd1, 32'd1);
        repeat (20) @(negedge clk);
        rreg(3'd4, v);
        chk(v == 32'd0 && cap_n == 0 && mem[BASE] == OWN, "R1 poll ignored while disabled", v, 32'd0);

        wreg(3'd3, TXEN);

        // R4 R5 R2: length sweep, single descriptor ring
        for (int L = 1; L <= 9; L++) begin
            clear_ring();
            set_desc(0, OWN, FS | LS | EOR | 32'(L), BUF0);
            fill_buf(BUF0, L, L);
            poll_wait();
            chk(cap_n == L, "R4 byte count", 32'(cap_n), 32'(L));
            ok = 1; nf = 0; nl = 0;
            for (int i = 0; i < L && i < cap_n; i++) begin
                if (cap_d[i] !== pat(L, i)) ok = 0;
                if (cap_f[i]) nf = nf + ((i == 0) ? 1 : 100);
                if (cap_l[i]) nl = nl + ((i == L-1) ? 1 : 100);
            end
            chk(ok, "R4 little-endian byte order", 32'(L), 32'(L));
            chk(nf == 1 && nl == 1, "R5 first/last markers", 32'(nf*256 + nl), 32'h101);
            chk(mem[BASE] == 32'd0, "R2 normal completion status", mem[BASE], 32'd0);
        end

        // R3: suspended on the unowned descriptor
        rreg(3'd4, v);
        chk(v == 32'h0060_0000, "R3 R9 suspended state code", v, 32'h0060_0000);

        // R5 R8: three-descriptor ring with wrap
        clear_ring();
        set_desc(0, OWN, FS | 32'd5, BUF0);
        set_desc(1, OWN, 32'd3, BUF0 + 8);
        set_desc(2, OWN, LS | EOR | 32'd4, BUF0 + 16);
        fill_buf(BUF0, 20, 5);
        fill_buf(BUF0 + 8, 21, 3);
        fill_buf(BUF0 + 16, 22, 4);
        poll_wait();
        chk(cap_n == 12, "R4 ring total bytes", 32'(cap_n), 32'd12);
        ok = 1; nf = 0; nl = 0;
        for (int i = 0; i < 12; i++) begin
            if (cap_d[i] !== (i < 5 ? pat(20, i) : i < 8 ? pat(21, i-5) : pat(22, i-8))) ok = 0;
            if (cap_f[i]) nf = nf + ((i == 0) ? 1 : 100);
            if (cap_l[i]) nl = nl + ((i == 11) ? 1 : 100);
        end
        chk(ok, "R8 ring order of descriptors", 32'd0, 32'd0);
        chk(nf == 1 && nl == 1, "R5 markers across segments", 32'(nf*256 + nl), 32'h101);
        chk(mem[BASE] == 0 && mem[BASE+4] == 0 && mem[BASE+8] == 0,
            "R2 all ring statuses returned", mem[BASE+4], 32'd0);

        // R3 R8: re-own descriptor 0; the wrap brought the position back to it
        cap_n = 0;
        set_desc(0, OWN, FS | LS | 32'd2, BUF0 + 24);
        fill_buf(BUF0 + 24, 23, 2);
        poll_wait();
        chk(cap_n == 2 && cap_d[0] == pat(23, 0) && cap_d[1] == pat(23, 1),
            "R3 R8 resume at wrapped descriptor", 32'(cap_n), 32'd2);

        // R3: poll with nothing owned writes nothing
        wreg(3'd2, 32'(BASE));
        clear_ring();
        mem[BASE] = 32'h1234_5678;
        poll_wait();
        chk(cap_n == 0 && mem[BASE] == 32'h1234_5678, "R3 unowned left untouched", mem[BASE], 32'h1234_5678);

        // R6: setup frame
        clear_ring();
        set_desc(0, OWN, SET | EOR | 32'd192, BUF0);
        fill_buf(BUF0, 7, 192);
        poll_wait();
        chk(set_n == 192 && cap_n == 0, "R6 setup bytes routed to setup sink", 32'(set_n), 32'd192);
        chk(mem[BASE] == 32'h7FFF_FFFF, "R6 setup completion status", mem[BASE], 32'h7FFF_FFFF);

        // R7: zero length
        clear_ring();
        set_desc(0, OWN, FS | LS | EOR, BUF0);
        poll_wait();
        chk(cap_n == 0 && mem[BASE] == 32'h0000_8000, "R7 zero length error status", mem[BASE], 32'h0000_8000);

        // R1: disabled from suspended keeps it there
        wreg(3'd3, 32'd0);
        clear_ring();
        set_desc(0, OWN, FS | LS | EOR | 32'd4, BUF0);
        wreg(3'd1, 32'd1);
        repeat (20) @(negedge clk);
        rreg(3'd4, v);
        chk(v == 32'h0060_0000 && cap_n == 0 && mem[BASE] == (OWN | 32'd0),
            "R1 disabled poll no effect", v, 32'h0060_0000);
        wreg(3'd3, TXEN);

        // R10: software reset mid-buffer
        clear_ring();
        set_desc(0, OWN, FS | LS | 32'd2, BUF0);
        set_desc(1, OWN, FS | LS | 32'd40, BUF1);
        fill_buf(BUF0, 40, 2);
        fill_buf(BUF1, 41, 40);
        wreg(3'd1, 32'd1);
        for (int i = 0; i < 2000 && cap_n < 6; i++) @(negedge clk);
        wreg(3'd0, 32'd1);
        rreg(3'd4, v);
        chk(v == 32'd0, "R10 state after software reset", v, 32'd0);
        c0 = cap_n;
        repeat (30) @(negedge clk);
        chk(cap_n == c0 && mem[BASE+4][31], "R10 output stopped", 32'(cap_n), 32'(c0));
        cap_n = 0;
        set_desc(0, OWN, FS | LS | 32'd3, BUF0);
        fill_buf(BUF0, 42, 3);
        poll_wait();
        chk(cap_n == 43 && cap_d[0] == pat(42, 0) && cap_d[2] == pat(42, 2) && cap_d[3] == pat(41, 0),
            "R10 position back at ring base", 32'(cap_n), 32'd43);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule